// File: doc/BRIEF.md
# Ethernet Frame Timestamp Capture Unit

This block keeps a time-of-day clock for precision time synchronisation and stamps Ethernet frames with it as they cross the boundary toward the physical layer. The clock is a seconds field and a nanoseconds field. It advances by a fixed step on every edge of a dedicated reference clock, which is separate from the clock that carries the frame bytes. Software may load a new seconds and nanoseconds pair in one write. The same counter drives a pulse-per-second output that is high during the first millisecond of each second.

On the byte-wide receive stream, every frame start is stamped, whatever the frame holds. On the transmit stream, the stamp is taken on the cycle the start-of-frame delimiter byte goes out after its preamble. The time value is carried into the data clock domain by a request/acknowledge handshake, so a capture never sees a half-updated seconds/nanoseconds pair. Each direction keeps its stamp, with a valid flag and an overflow flag, until the descriptor logic acknowledges it.

Top module: `frame_stamp_unit`

## Requirements
- R1: On each reference-clock edge with no load, the nanoseconds field increases by 10 and the seconds field is unchanged, as long as nanoseconds is below 999,999,990.
- R2: When nanoseconds is 999,999,990 and no load is requested, the next reference edge sets nanoseconds to 0 and increments seconds by one.
- R3: When `loadStb` is high at a reference edge, the time takes the values `loadSec`/`loadNs` at that edge, in place of the increment.
- R4: `pps` is high exactly while nanoseconds is below 1,000,000. It therefore rises when nanoseconds wraps to 0 and stays high for one millisecond of counted time.
- R5: A transmit stamp is taken when `txValid` is high, `txSof` is low and `txData` is 0xD5, provided the frame opened with `txSof` on a 0x55 byte and every byte since then was 0x55. Only one stamp is taken per frame. A 0xD5 byte that does not follow such a run, including one that carries `txSof`, is ignored.
- R6: A receive stamp is taken on every cycle with `rxValid` and `rxSof` both high, whatever the frame contents.
- R7: A stamp is presented with its valid flag on the data-clock cycle after the capture. It stays unchanged until an acknowledge, and the valid flag clears on the cycle after the acknowledge.
- R8: A capture in a direction whose stamp is still valid and not being acknowledged overwrites that stamp and raises that direction's overflow flag. An acknowledge clears the overflow flag.
- R9: A captured stamp is a coherent seconds/nanoseconds pair. It is no later than the reference time at capture and no more than 300 ns older, including across a seconds wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ptpClk | input | 1 | Reference clock for the time counter |
| ptpRstN | input | 1 | Active-low reset, reference domain |
| loadStb | input | 1 | Load request, reference domain |
| loadSec | input | 32 | Seconds value to load |
| loadNs | input | 30 | Nanoseconds value to load |
| pps | output | 1 | Pulse-per-second output |
| clk | input | 1 | Data clock of the byte streams |
| rstN | input | 1 | Active-low reset, data domain |
| rxValid | input | 1 | Receive byte valid |
| rxSof | input | 1 | Receive start-of-frame marker |
| txValid | input | 1 | Transmit byte valid |
| txSof | input | 1 | Transmit start-of-frame marker |
| txData | input | 8 | Transmit byte |
| rxStampAck | input | 1 | Acknowledge for the receive stamp |
| txStampAck | input | 1 | Acknowledge for the transmit stamp |
| rxStampSec | output | 32 | Receive stamp seconds |
| rxStampNs | output | 30 | Receive stamp nanoseconds |
| rxStampValid | output | 1 | Receive stamp present |
| rxStampOvf | output | 1 | Receive stamp overwritten before acknowledge |
| txStampSec | output | 32 | Transmit stamp seconds |
| txStampNs | output | 30 | Transmit stamp nanoseconds |
| txStampValid | output | 1 | Transmit stamp present |
| txStampOvf | output | 1 | Transmit stamp overwritten before acknowledge |

## Verification
The hardest case to reach from the ports is a capture that lands while the seconds field is rolling over. That is the only moment when a torn seconds/nanoseconds pair would be visible, and at power-up that moment is a full second away. The stimulus loads a time a few hundred nanoseconds before the wrap. It then sends a dense train of receive frames across the wrap and checks each stamp against a reference time kept in the bench. The delimiter rules are covered with frames whose 0xD5 byte carries the start marker, follows a broken preamble, or appears again in the payload.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int SEC_W = 32;
  localparam int NS_W  = 30;
  localparam int DIRS  = 2;   // index 0 receive, 1 transmit

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } tod_t;

  typedef struct packed {
    logic txCap;
    logic rxCap;
  } capStb_t;
endpackage

// File: rtl/stamp_ctrl.sv
module stamp_ctrl
  import stamp_pkg::*;
#(
  parameter logic [7:0] PRE_BYTE = 8'h55,
  parameter logic [7:0] SFD_BYTE = 8'hD5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rxValid,
  input  logic            rxSof,
  input  logic            txValid,
  input  logic            txSof,
  input  logic [7:0]      txData,
  input  logic [DIRS-1:0] ackV,
  output capStb_t         cap,
  output logic [DIRS-1:0] vld,
  output logic [DIRS-1:0] ovf
);
  logic armed;
  logic [DIRS-1:0] capV;

  always_comb begin
    cap.rxCap = rxValid && rxSof;
    cap.txCap = txValid && !txSof && armed && (txData == SFD_BYTE);
    capV = {cap.txCap, cap.rxCap};
  end

  // preamble tracker: armed while the frame so far is a run of preamble bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (txValid) begin
      if (txSof) armed <= (txData == PRE_BYTE);
      else if (txData != PRE_BYTE) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
      ovf <= '0;
    end else begin
      for (int d = 0; d < DIRS; d++) begin
        if (capV[d]) begin
          vld[d] <= 1'b1;
          ovf[d] <= vld[d] && !ackV[d];
        end else if (ackV[d]) begin
          vld[d] <= 1'b0;
          ovf[d] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/stamp_dp.sv
module stamp_dp
  import stamp_pkg::*;
#(
  parameter int STEP_NS    = 10,
  parameter int NS_PER_SEC = 1_000_000_000,
  parameter int PPS_NS     = 1_000_000
) (
  input  logic             ptpClk,
  input  logic             ptpRstN,
  input  logic             loadStb,
  input  logic [SEC_W-1:0] loadSec,
  input  logic [NS_W-1:0]  loadNs,
  output logic             pps,
  output tod_t             nowTod,
  input  logic             clk,
  input  logic             rstN,
  input  capStb_t          cap,
  output tod_t             stamp [DIRS]
);
  localparam logic [NS_W-1:0] STEP_V  = NS_W'(STEP_NS);
  localparam logic [NS_W-1:0] LIMIT_V = NS_W'(NS_PER_SEC);
  localparam logic [NS_W-1:0] WRAP_AT = NS_W'(NS_PER_SEC - STEP_NS);
  localparam logic [NS_W-1:0] PPS_V   = NS_W'(PPS_NS);

  tod_t       tod, hold, timeNow;
  logic       reqTgl, ackTgl;
  logic [1:0] ackSync, reqSync;
  logic [DIRS-1:0] capV;

  // reference domain: time counter and handshake source
  always_ff @(posedge ptpClk or negedge ptpRstN) begin
    if (!ptpRstN) begin
      tod     <= '0;
      hold    <= '0;
      reqTgl  <= 1'b0;
      ackSync <= '0;
    end else begin
      if (loadStb) begin
        tod.sec <= loadSec;
        tod.ns  <= loadNs;
      end else if (tod.ns >= WRAP_AT) begin
        tod.ns  <= tod.ns + STEP_V - LIMIT_V;
        tod.sec <= tod.sec + 1'b1;
      end else begin
        tod.ns  <= tod.ns + STEP_V;
      end
      ackSync <= {ackSync[0], ackTgl};
      if (ackSync[1] == reqTgl) begin
        hold   <= tod;
        reqTgl <= ~reqTgl;
      end
    end
  end

  assign pps    = tod.ns < PPS_V;
  assign nowTod = tod;

  // data domain: handshake sink, hold is stable while the request is open
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqSync <= '0;
      ackTgl  <= 1'b0;
      timeNow <= '0;
    end else begin
      reqSync <= {reqSync[0], reqTgl};
      if (reqSync[1] != ackTgl) begin
        timeNow <= hold;
        ackTgl  <= reqSync[1];
      end
    end
  end

  assign capV = {cap.txCap, cap.rxCap};

  for (genvar d = 0; d < DIRS; d++) begin : g_dir
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stamp[d] <= '0;
      else if (capV[d]) stamp[d] <= timeNow;
    end
  end
endmodule

// File: rtl/frame_stamp_unit.sv
module frame_stamp_unit
  import stamp_pkg::*;
#(
  parameter int STEP_NS    = 10,
  parameter int NS_PER_SEC = 1_000_000_000,
  parameter int PPS_NS     = 1_000_000
) (
  input  logic        ptpClk,
  input  logic        ptpRstN,
  input  logic        loadStb,
  input  logic [31:0] loadSec,
  input  logic [29:0] loadNs,
  output logic        pps,
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        rxSof,
  input  logic        txValid,
  input  logic        txSof,
  input  logic [7:0]  txData,
  input  logic        rxStampAck,
  input  logic        txStampAck,
  output logic [31:0] rxStampSec,
  output logic [29:0] rxStampNs,
  output logic        rxStampValid,
  output logic        rxStampOvf,
  output logic [31:0] txStampSec,
  output logic [29:0] txStampNs,
  output logic        txStampValid,
  output logic        txStampOvf
);
  capStb_t         cap;
  tod_t            nowTod;
  tod_t            stamp [DIRS];
  logic [DIRS-1:0] vld, ovf;
  logic [31:0]     nowSec;
  logic [29:0]     nowNs;

  stamp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof),
    .txValid(txValid), .txSof(txSof), .txData(txData),
    .ackV({txStampAck, rxStampAck}), .cap(cap), .vld(vld), .ovf(ovf)
  );

  stamp_dp #(.STEP_NS(STEP_NS), .NS_PER_SEC(NS_PER_SEC), .PPS_NS(PPS_NS)) u_dp (
    .ptpClk(ptpClk), .ptpRstN(ptpRstN), .loadStb(loadStb), .loadSec(loadSec),
    .loadNs(loadNs), .pps(pps), .nowTod(nowTod), .clk(clk), .rstN(rstN),
    .cap(cap), .stamp(stamp)
  );

  assign nowSec       = nowTod.sec;
  assign nowNs        = nowTod.ns;
  assign rxStampSec   = stamp[0].sec;
  assign rxStampNs    = stamp[0].ns;
  assign txStampSec   = stamp[1].sec;
  assign txStampNs    = stamp[1].ns;
  assign rxStampValid = vld[0];
  assign txStampValid = vld[1];
  assign rxStampOvf   = ovf[0];
  assign txStampOvf   = ovf[1];
endmodule

// File: rtl/stamp_chk.sv
module stamp_chk #(
  parameter int STEP_NS    = 10,
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input logic        ptpClk,
  input logic        ptpRstN,
  input logic        loadStb,
  input logic [31:0] loadSec,
  input logic [29:0] loadNs,
  input logic        pps,
  input logic [31:0] nowSec,
  input logic [29:0] nowNs,
  input logic        clk,
  input logic        rstN,
  input logic        rxValid,
  input logic        rxSof,
  input logic        txValid,
  input logic [31:0] rxStampSec,
  input logic [29:0] rxStampNs,
  input logic        rxStampValid,
  input logic        rxStampOvf,
  input logic [31:0] txStampSec,
  input logic [29:0] txStampNs,
  input logic        txStampValid,
  input logic        txStampOvf
);
  localparam logic [29:0] STEP_V = 30'(STEP_NS);
  localparam logic [29:0] WRAP_V = 30'(NS_PER_SEC - STEP_NS);

  a_r1_ns_step: assert property (@(posedge ptpClk) disable iff (!ptpRstN)
    (!loadStb && nowNs < WRAP_V) |=> (nowNs == $past(nowNs) + STEP_V) && $stable(nowSec));

  a_r2_sec_wrap: assert property (@(posedge ptpClk) disable iff (!ptpRstN)
    (!loadStb && nowNs == WRAP_V) |=> (nowNs == 30'd0) && (nowSec == $past(nowSec) + 32'd1));

  a_r3_load: assert property (@(posedge ptpClk) disable iff (!ptpRstN)
    loadStb |=> (nowSec == $past(loadSec)) && (nowNs == $past(loadNs)));

  a_r4_pps_rise: assert property (@(posedge ptpClk) disable iff (!ptpRstN)
    $rose(pps) |-> (nowNs < STEP_V) || $past(loadStb));

  a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxStampValid && !(rxValid && rxSof)) |=> $stable(rxStampNs) && $stable(rxStampSec));

  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txStampValid && !txValid) |=> $stable(txStampNs) && $stable(txStampSec));

  a_r8_rx_ovf_valid: assert property (@(posedge clk) disable iff (!rstN)
    rxStampOvf |-> rxStampValid);

  a_r8_tx_ovf_valid: assert property (@(posedge clk) disable iff (!rstN)
    txStampOvf |-> txStampValid);
endmodule

bind frame_stamp_unit stamp_chk #(.STEP_NS(STEP_NS), .NS_PER_SEC(NS_PER_SEC)) u_chk (.*);

// File: tb/test_frame_stamp_unit.sv
`timescale 1ns/1ps
module test_frame_stamp_unit;
  logic        ptpClk = 0, ptpRstN = 0, clk = 0, rstN = 0;
  logic        loadStb = 0;
  logic [31:0] loadSec = 0;
  logic [29:0] loadNs = 0;
  logic        pps;
  logic        rxValid = 0, rxSof = 0, txValid = 0, txSof = 0;
  logic [7:0]  txData = 0;
  logic        rxStampAck = 0, txStampAck = 0;
  logic [31:0] rxStampSec, txStampSec;
  logic [29:0] rxStampNs, txStampNs;
  logic        rxStampValid, rxStampOvf, txStampValid, txStampOvf;

  frame_stamp_unit i_frame_stamp_unit (.*);

  always #2 clk = ~clk;      // 250 MHz data clock
  always #5 ptpClk = ~ptpClk; // 100 MHz reference clock

  int checks = 0, errors = 0, rxSeen = 0, txSeen = 0;
  bit autoAck = 0, done = 0;
  longint unsigned modelT;
  longint unsigned rxQ[$], txQ[$];

  // reference time from R1-style stepping, R2 carry and R3 load
  always @(posedge ptpClk)
    if (!ptpRstN) modelT <= 0;
    else if (loadStb) modelT <= longint'(loadSec) * 64'd1000000000 + longint'(loadNs);
    else modelT <= modelT + 10;

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkNear(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act > exp + 20 || act + 300 < exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (-300..+20)", req, act, exp);
    end
  endtask

  function automatic longint unsigned total(logic [31:0] s, logic [29:0] n);
    return longint'(s) * 64'd1000000000 + longint'(n);
  endfunction

  task automatic loadTime(logic [31:0] s, logic [29:0] n, int settle);
    @(negedge ptpClk);
    loadStb = 1; loadSec = s; loadNs = n;
    @(negedge ptpClk);
    loadStb = 0;
    repeat (settle) @(negedge clk);
  endtask

  task automatic txByte(logic [7:0] b, logic s);
    @(negedge clk);
    txValid = 1; txData = b; txSof = s;
  endtask

  task automatic txIdle();
    @(negedge clk);
    txValid = 0; txSof = 0;
  endtask

  // good transmit frame: preamble, delimiter, payload carrying more 0x55/0xD5
  task automatic sendTx(bit push);
    txByte(8'h55, 1);
    for (int i = 0; i < 6; i++) txByte(8'h55, 0);
    @(negedge clk);
    txValid = 1; txData = 8'hD5; txSof = 0;
    if (push) txQ.push_back(modelT);
    txByte(8'h11, 0); txByte(8'h55, 0); txByte(8'hD5, 0); txByte(8'hD5, 0);
    txIdle();
  endtask

  task automatic sendRx(bit push, output longint unsigned t);
    @(negedge clk);
    rxValid = 1; rxSof = 1; t = modelT;
    if (push) rxQ.push_back(modelT);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rxSof = 0;
    end
    @(negedge clk);
    rxValid = 0;
  endtask

  // scoreboard monitor: pops expected stamps as the design presents them
  always @(negedge clk) begin
    if (autoAck && rstN) begin
      if (rxStampValid && !rxStampAck) begin
        if (rxQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6 unexpected rx stamp actual %0d expected none", total(rxStampSec, rxStampNs));
        end else checkNear("R6/R9 rx stamp", total(rxStampSec, rxStampNs), rxQ.pop_front());
        rxSeen++;
        rxStampAck = 1;
      end else rxStampAck = 0;
      if (txStampValid && !txStampAck) begin
        if (txQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 unexpected tx stamp actual %0d expected none", total(txStampSec, txStampNs));
        end else checkNear("R5/R9 tx stamp", total(txStampSec, txStampNs), txQ.pop_front());
        txSeen++;
        txStampAck = 1;
      end else txStampAck = 0;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint unsigned t1, t2, held;
    repeat (5) @(negedge ptpClk);
    rstN = 1; ptpRstN = 1;
    @(negedge clk);
    // R7 reset state, R4 pps at time zero
    check("R7 reset rx valid", rxStampValid, 0);
    check("R7 reset tx valid", txStampValid, 0);
    check("R8 reset rx ovf", rxStampOvf, 0);
    check("R8 reset tx ovf", txStampOvf, 0);
    check("R4 pps after reset", pps, 1);

    // R3 load then R5 / R6 captures via scoreboard
    loadTime(32'd100, 30'd500_000_000, 40);
    autoAck = 1;
    sendTx(1);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      sendRx(1, t1);
      repeat (4) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check("R5 one tx stamp per frame", txSeen, 1);
    check("R6 rx stamp per frame", rxSeen, 3);

    // R5 ignored delimiters: delimiter carrying sof, broken preamble
    txByte(8'hD5, 1); txByte(8'h00, 0); txIdle();
    txByte(8'h55, 1); txByte(8'h55, 0); txByte(8'h12, 0); txByte(8'hD5, 0); txIdle();
    txByte(8'h33, 1); txByte(8'h55, 0); txByte(8'hD5, 0); txIdle();
    repeat (5) @(negedge clk);
    check("R5 stray 0xD5 ignored, valid", txStampValid, 0);
    check("R5 stray 0xD5 ignored, count", txSeen, 1);

    // R2 / R9: dense receive train across a seconds wrap
    loadTime(32'd41, 30'd999_999_700, 40);
    for (int i = 0; i < 12; i++) sendRx(1, t1);
    sendTx(1);
    repeat (10) @(negedge clk);
    check("R2 rx stamps across wrap", rxSeen, 15);
    check("R2 seconds after wrap", rxStampSec, 42);

    // R4 pps edges
    autoAck = 0;
    @(negedge ptpClk);
    loadStb = 1; loadSec = 32'd3; loadNs = 30'd999_999_980;
    @(negedge ptpClk); loadStb = 0;
    check("R4 pps low before wrap", pps, 0);
    @(negedge ptpClk);
    check("R4 pps low at 999999990", pps, 0);
    @(negedge ptpClk);
    check("R4 pps high after wrap", pps, 1);
    check("R1 model ns after wrap", modelT % 64'd1000000000, 0);
    @(negedge ptpClk);
    loadStb = 1; loadNs = 30'd999_980;
    @(negedge ptpClk); loadStb = 0;
    check("R4 pps high below 1 ms", pps, 1);
    repeat (2) @(negedge ptpClk);
    check("R4 pps low at 1 ms", pps, 0);

    // R8 overflow and R7 hold, receive
    repeat (60) @(negedge clk);
    sendRx(0, t1);
    repeat (200) @(negedge clk);
    sendRx(0, t2);
    repeat (3) @(negedge clk);
    check("R8 rx valid after two captures", rxStampValid, 1);
    check("R8 rx ovf after two captures", rxStampOvf, 1);
    checkNear("R8 rx newer stamp kept", total(rxStampSec, rxStampNs), t2);
    held = total(rxStampSec, rxStampNs);
    repeat (20) @(negedge clk);
    check("R7 rx stamp held until ack", total(rxStampSec, rxStampNs), held);
    check("R7 rx valid held until ack", rxStampValid, 1);
    rxStampAck = 1; @(negedge clk); rxStampAck = 0;
    check("R7 rx valid cleared by ack", rxStampValid, 0);
    check("R8 rx ovf cleared by ack", rxStampOvf, 0);

    // R8 overflow, transmit
    sendTx(0);
    repeat (5) @(negedge clk);
    check("R8 tx single capture no ovf", txStampOvf, 0);
    sendTx(0);
    repeat (3) @(negedge clk);
    check("R8 tx ovf after second frame", txStampOvf, 1);
    txStampAck = 1; @(negedge clk); txStampAck = 0;
    check("R8 tx ovf cleared by ack", txStampOvf, 0);
    check("R7 tx valid cleared by ack", txStampValid, 0);

    check("R6 rx queue drained", rxQ.size(), 0);
    check("R5 tx queue drained", txQ.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule